// File: doc/BRIEF.md
# Banked Level-Sensitive Interrupt Controller

This block collects level-sensitive interrupt requests from 96 sources, or 128 with a parameter, and drives a single interrupt line toward a processor. The sources are grouped into banks of 32. Each bank has a mask word, two write-only alias addresses that set or clear mask bits, and a read-only pending word. The pending word shows the raw request levels with the masked bits forced to zero.

When nothing is latched, the controller picks the lowest-numbered unmasked request and holds its number in an active-source register. It raises the processor line and keeps that source latched until software writes the acknowledge bit. This holds even if the source is later masked or drops its request. After an acknowledge, the line stays low for two cycles before another source can be latched.

A soft reset, started from the configuration register, returns the block to its power-on state in a fixed number of cycles and reports completion in a status bit. A revision word and several store-only configuration words (protection, idle, threshold, per-source level) complete the register set.

Top module: `banked_irq_ctrl`

## Requirements
- R1: After a hardware reset, and after a soft reset completes, every mask bit is 1, no source is latched (active register reads 0 and `irq_out` is 0), and the configuration, threshold and per-source level words read 0.
- R2: Bank b's mask word reads at 0x084+0x20*b. Writes to that address are ignored. Writing the clear alias at 0x088+0x20*b clears (unmasks) each mask bit written as 1 and leaves the bits written as 0 unchanged.
- R3: Writing the set alias at 0x08C+0x20*b sets (masks) each mask bit written as 1 and leaves the bits written as 0 unchanged.
- R4: The pending word of bank b at 0x098+0x20*b reads the raw request bits of sources 32*b..32*b+31 ANDed with the inverse of that bank's mask.
- R5: While nothing is latched and no acknowledge gap is running, an edge that sees any pending source latches the lowest-numbered pending source number into bits [6:0] of the active register at 0x040, and `irq_out` rises in the same edge.
- R6: Once a source is latched, `irq_out` and the active number hold steady until an acknowledge, even if that source is masked or deasserted or a lower-numbered source becomes pending.
- R7: A write to 0x048 with bit 0 set clears the latch: `irq_out` is 0 after that edge and after the following one, the active register reads 0, and re-evaluation happens on the edge after that.
- R8: A write to 0x010 with bit 1 set starts a soft reset. The status word at 0x014 bit 0 reads 0 for exactly 4 cycles after the write edge and 1 otherwise. Bus writes that land while the soft reset is running are ignored.
- R9: The revision word at 0x000 holds the major version in bits [7:4] and the minor version in bits [3:0], both set by parameters. All its other bits are 0.
- R10: These words store their written values and read them back: configuration bit 0 at 0x010, protection bit 0 at 0x04C, idle bits [1:0] at 0x050, threshold bits [7:0] at 0x068, and per-source level bits [7:0] at 0x100+4*n for each source n. Unmapped addresses read 0.
- R11: `NUM_BANKS` may only be 3 or 4. Any other value stops elaboration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_irq | input | 32*NUM_BANKS | Level request per source |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 12 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| irq_out | output | 1 | Interrupt line toward the processor |

## Verification
The bench builds the controller with `NUM_BANKS` = 4. This makes the fourth bank, its alias and pending addresses, and source 127 reachable, so the top bit of the 7-bit active number is checked along with lowest-number selection across banks. It also places the last per-source level word at 0x2FC, so the top of the level window is covered. The default three-bank build is covered only by elaboration.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
   localparam int ADDR_W      = 12;
   localparam int DATA_W      = 32;
   localparam int BANK_W      = 32;
   localparam int SRST_CYCLES = 4;

   // fixed register locations
   localparam logic [ADDR_W-1:0] A_REV     = 12'h000;
   localparam logic [ADDR_W-1:0] A_SYSCFG  = 12'h010;
   localparam logic [ADDR_W-1:0] A_SYSSTAT = 12'h014;
   localparam logic [ADDR_W-1:0] A_ACTIVE  = 12'h040;
   localparam logic [ADDR_W-1:0] A_CTRL    = 12'h048;
   localparam logic [ADDR_W-1:0] A_PROT    = 12'h04C;
   localparam logic [ADDR_W-1:0] A_IDLE    = 12'h050;
   localparam logic [ADDR_W-1:0] A_THRESH  = 12'h068;
   localparam logic [ADDR_W-1:0] A_LVL     = 12'h100;

   // bank window 0x080..0x0FF, 0x20 bytes per bank
   localparam logic [4:0] WIN_TAG  = 5'b00001;
   localparam logic [4:0] OFS_MASK = 5'h04;
   localparam logic [4:0] OFS_CLR  = 5'h08;
   localparam logic [4:0] OFS_SET  = 5'h0C;
   localparam logic [4:0] OFS_PEND = 5'h18;

   typedef struct packed {
      logic clr;
      logic set;
   } bank_wr_t;
endpackage

// File: rtl/irqc_bank.sv
module irqc_bank
   import irqc_pkg::*;
#(
   parameter int W = BANK_W
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         soft_clr,
   input  bank_wr_t     wr,
   input  logic [W-1:0] wbits,
   input  logic [W-1:0] raw,
   output logic [W-1:0] mask_q,
   output logic [W-1:0] pend
);
   logic [W-1:0] mask_d;

   always_comb begin
      mask_d = mask_q;
      if (wr.set) mask_d = mask_d | wbits;
      if (wr.clr) mask_d = mask_d & ~wbits;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        mask_q <= '1;
      else if (soft_clr) mask_q <= '1;
      else               mask_q <= mask_d;
   end

   assign pend = raw & ~mask_q;
endmodule

// File: rtl/irqc_prio_enc.sv
module irqc_prio_enc #(
   parameter int N  = 96,
   parameter int IW = $clog2(N)
) (
   input  logic [N-1:0]  req,
   output logic          any,
   output logic [IW-1:0] idx
);
   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) idx = IW'(i);
      end
   end

   assign any = |req;
endmodule

// File: rtl/irqc_cfg_regs.sv
module irqc_cfg_regs
   import irqc_pkg::*;
#(
   parameter int NUM_SRC = 96,
   parameter int LVL_W   = 8,
   parameter int TH_W    = 8,
   parameter int FIELD_W = 8,
   localparam int IW     = $clog2(NUM_SRC)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               soft_clr,
   input  logic               we,
   input  logic [ADDR_W-1:0]  addr,
   input  logic [FIELD_W-1:0] wdata,
   output logic [DATA_W-1:0]  rdata
);
   logic              autoidle_q;
   logic              prot_q;
   logic [1:0]        idle_q;
   logic [TH_W-1:0]   thresh_q;
   logic [LVL_W-1:0]  lvl_q [NUM_SRC];

   logic [ADDR_W-3:0] lvl_idx;
   logic [IW-1:0]     lvl_sel;
   logic              lvl_hit;

   assign lvl_idx = addr[ADDR_W-1:2] - A_LVL[ADDR_W-1:2];
   assign lvl_sel = lvl_idx[IW-1:0];
   assign lvl_hit = (addr >= A_LVL) && (addr[1:0] == 2'b00) && (int'(lvl_idx) < NUM_SRC);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n || soft_clr) begin
         autoidle_q <= 1'b0;
         prot_q     <= 1'b0;
         idle_q     <= '0;
         thresh_q   <= '0;
      end else if (we) begin
         if (addr == A_SYSCFG) autoidle_q <= wdata[0];
         if (addr == A_PROT)   prot_q     <= wdata[0];
         if (addr == A_IDLE)   idle_q     <= wdata[1:0];
         if (addr == A_THRESH) thresh_q   <= wdata[TH_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n || soft_clr) begin
         for (int i = 0; i < NUM_SRC; i++) lvl_q[i] <= '0;
      end else if (we && lvl_hit) begin
         lvl_q[lvl_sel] <= wdata[LVL_W-1:0];
      end
   end

   always_comb begin
      rdata = '0;
      if (addr == A_SYSCFG)      rdata = DATA_W'(autoidle_q);
      else if (addr == A_PROT)   rdata = DATA_W'(prot_q);
      else if (addr == A_IDLE)   rdata = DATA_W'(idle_q);
      else if (addr == A_THRESH) rdata = DATA_W'(thresh_q);
      else if (lvl_hit)          rdata = DATA_W'(lvl_q[lvl_sel]);
   end
endmodule

// File: rtl/banked_irq_ctrl.sv
module banked_irq_ctrl
   import irqc_pkg::*;
#(
   parameter int         NUM_BANKS = 3,
   parameter int         LVL_W     = 8,
   parameter int         TH_W      = 8,
   parameter logic [3:0] REV_MAJOR = 4'h4,
   parameter logic [3:0] REV_MINOR = 4'h1,
   localparam int NUM_SRC = NUM_BANKS * BANK_W,
   localparam int ID_W    = $clog2(NUM_SRC),
   localparam int FIELD_W = (LVL_W > TH_W) ? LVL_W : TH_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_irq,
   input  logic               bus_sel,
   input  logic               bus_we,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [DATA_W-1:0]  bus_wdata,
   output logic [DATA_W-1:0]  bus_rdata,
   output logic               irq_out
);
   // R11: elaboration-time parameter checks
   generate
      if (NUM_BANKS != 3 && NUM_BANKS != 4) begin : g_bad_banks
         $error("banked_irq_ctrl: NUM_BANKS must be 3 or 4");
      end
      if (LVL_W < 2 || LVL_W > 32 || TH_W < 2 || TH_W > 32) begin : g_bad_width
         $error("banked_irq_ctrl: LVL_W and TH_W must lie in 2..32");
      end
      if (ID_W > 7) begin : g_bad_id
         $error("banked_irq_ctrl: source number exceeds 7 bits");
      end
   endgenerate

   localparam int SC_W = $clog2(SRST_CYCLES + 1);

   logic              srst_busy;
   logic [SC_W-1:0]   srst_cnt;
   logic              wr_ok;
   logic              srst_req;
   logic              ack_wr;
   logic              in_win;
   logic [1:0]        bk_sel;
   logic [4:0]        bk_ofs;
   logic              bk_valid;

   logic [BANK_W-1:0]  mask_w [NUM_BANKS];
   logic [BANK_W-1:0]  pend_w [NUM_BANKS];
   logic [NUM_SRC-1:0] mask_all;
   logic [NUM_SRC-1:0] pend_all;

   logic              enc_any;
   logic [ID_W-1:0]   enc_idx;
   logic              act_vld;
   logic [ID_W-1:0]   act_id;
   logic              ack_gap;
   logic [DATA_W-1:0] cfg_rdata;

   // ---------------- bus decode ----------------
   assign wr_ok    = bus_sel && bus_we && !srst_busy;
   assign srst_req = wr_ok && (bus_addr == A_SYSCFG) && bus_wdata[1];
   assign ack_wr   = wr_ok && (bus_addr == A_CTRL) && bus_wdata[0];
   assign in_win   = (bus_addr[ADDR_W-1:7] == WIN_TAG);
   assign bk_sel   = bus_addr[6:5];
   assign bk_ofs   = bus_addr[4:0];
   assign bk_valid = in_win && (int'(bk_sel) < NUM_BANKS);

   // ---------------- soft reset sequencer ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         srst_cnt <= '0;
      else if (srst_busy) srst_cnt <= srst_cnt - 1'b1;
      else if (srst_req)  srst_cnt <= SC_W'(SRST_CYCLES);
   end
   assign srst_busy = (srst_cnt != '0);

   // ---------------- mask banks ----------------
   generate
      for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
         bank_wr_t bwr;
         assign bwr.clr = wr_ok && in_win && (bk_sel == 2'(b)) && (bk_ofs == OFS_CLR);
         assign bwr.set = wr_ok && in_win && (bk_sel == 2'(b)) && (bk_ofs == OFS_SET);

         irqc_bank #(.W(BANK_W)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .soft_clr (srst_busy),
            .wr       (bwr),
            .wbits    (bus_wdata),
            .raw      (src_irq[b*BANK_W +: BANK_W]),
            .mask_q   (mask_w[b]),
            .pend     (pend_w[b])
         );

         assign mask_all[b*BANK_W +: BANK_W] = mask_w[b];
         assign pend_all[b*BANK_W +: BANK_W] = pend_w[b];
      end
   endgenerate

   // ---------------- selection and latch ----------------
   irqc_prio_enc #(.N(NUM_SRC), .IW(ID_W)) u_enc (
      .req (pend_all),
      .any (enc_any),
      .idx (enc_idx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n || srst_busy) begin
         act_vld <= 1'b0;
         act_id  <= '0;
         ack_gap <= 1'b0;
      end else if (ack_wr) begin
         act_vld <= 1'b0;
         act_id  <= '0;
         ack_gap <= 1'b1;
      end else begin
         ack_gap <= 1'b0;
         if (!act_vld && !ack_gap && enc_any) begin
            act_vld <= 1'b1;
            act_id  <= enc_idx;
         end
      end
   end

   assign irq_out = act_vld;

   // ---------------- stored configuration ----------------
   irqc_cfg_regs #(
      .NUM_SRC (NUM_SRC),
      .LVL_W   (LVL_W),
      .TH_W    (TH_W),
      .FIELD_W (FIELD_W)
   ) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .soft_clr (srst_busy),
      .we       (wr_ok),
      .addr     (bus_addr),
      .wdata    (bus_wdata[FIELD_W-1:0]),
      .rdata    (cfg_rdata)
   );

   // ---------------- read mux ----------------
   always_comb begin
      bus_rdata = '0;
      if (bus_addr == A_REV) begin
         bus_rdata = {24'h0, REV_MAJOR, REV_MINOR};
      end else if (bus_addr == A_SYSSTAT) begin
         bus_rdata = DATA_W'(!srst_busy);
      end else if (bus_addr == A_ACTIVE) begin
         bus_rdata = DATA_W'(act_id);
      end else if (bk_valid) begin
         if (bk_ofs == OFS_MASK)      bus_rdata = mask_w[bk_sel];
         else if (bk_ofs == OFS_PEND) bus_rdata = pend_w[bk_sel];
      end else begin
         bus_rdata = cfg_rdata;
      end
   end
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk #(
   parameter int NUM_SRC = 96,
   parameter int ID_W    = 7
) (
   input logic               clk,
   input logic               rst_n,
   input logic               irq_out,
   input logic               ack_wr,
   input logic               srst_busy,
   input logic [ID_W-1:0]    act_id,
   input logic [NUM_SRC-1:0] mask_all,
   input logic [NUM_SRC-1:0] pend_all
);
   // R6
   hold_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_out && !ack_wr && !srst_busy) |=> irq_out);

   // R6
   hold_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_out && !ack_wr && !srst_busy) |=> $stable(act_id));

   // R7
   ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack_wr |=> !irq_out);

   // R7
   ack_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(ack_wr, 2) |-> !irq_out);

   // R5
   rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_out) |-> $past(|pend_all));

   // R1
   srst_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      srst_busy |=> (&mask_all));

   // R8
   srst_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      srst_busy |=> !irq_out);
endmodule

bind banked_irq_ctrl irqc_chk #(.NUM_SRC(NUM_SRC), .ID_W(ID_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .irq_out   (irq_out),
   .ack_wr    (ack_wr),
   .srst_busy (srst_busy),
   .act_id    (act_id),
   .mask_all  (mask_all),
   .pend_all  (pend_all)
);

// File: tb/tb_banked_irq_ctrl.sv
module tb_banked_irq_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int NB         = 4;
   localparam int NS         = NB * 32;

   localparam logic [1:0] OP_WR  = 2'd0;
   localparam logic [1:0] OP_RD  = 2'd1;
   localparam logic [1:0] OP_RAW = 2'd2;
   localparam logic [1:0] OP_IRQ = 2'd3;

   // {req[49:46], op[45:44], addr[43:32], data[31:0]}
   localparam int NV = 62;
   localparam logic [49:0] VEC [NV] = '{
      {4'd9,  OP_RD,  12'h000, 32'h0000_0041}, // R9 revision 4.1
      {4'd8,  OP_RD,  12'h014, 32'h0000_0001}, // R8 idle status
      {4'd1,  OP_RD,  12'h084, 32'hFFFF_FFFF}, // R1 masks set
      {4'd1,  OP_RD,  12'h0E4, 32'hFFFF_FFFF}, // R1 bank 3 mask
      {4'd7,  OP_RD,  12'h040, 32'h0000_0000}, // R7 nothing latched
      {4'd5,  OP_IRQ, 12'h000, 32'h0000_0000}, // R5 line low
      {4'd4,  OP_RAW, 12'h001, 32'h0000_0010}, // R4 source 36 raised
      {4'd4,  OP_RD,  12'h0B8, 32'h0000_0000}, // R4 masked, not pending
      {4'd4,  OP_IRQ, 12'h000, 32'h0000_0000}, // R4
      {4'd2,  OP_WR,  12'h0A8, 32'h0000_0010}, // R2 unmask 36
      {4'd2,  OP_RD,  12'h0A4, 32'hFFFF_FFEF}, // R2
      {4'd4,  OP_RD,  12'h0B8, 32'h0000_0010}, // R4
      {4'd5,  OP_RD,  12'h040, 32'h0000_0024}, // R5 latched 36
      {4'd5,  OP_IRQ, 12'h000, 32'h0000_0001}, // R5
      {4'd6,  OP_RAW, 12'h000, 32'h0000_0020}, // R6 source 5 raised
      {4'd6,  OP_WR,  12'h088, 32'h0000_0020}, // R6 unmask 5
      {4'd6,  OP_RD,  12'h040, 32'h0000_0024}, // R6 lower source does not preempt
      {4'd3,  OP_WR,  12'h0AC, 32'h0000_0010}, // R3 mask 36
      {4'd3,  OP_RD,  12'h0A4, 32'hFFFF_FFFF}, // R3
      {4'd3,  OP_RD,  12'h0B8, 32'h0000_0000}, // R3
      {4'd6,  OP_RD,  12'h040, 32'h0000_0024}, // R6 still latched
      {4'd6,  OP_IRQ, 12'h000, 32'h0000_0001}, // R6
      {4'd7,  OP_WR,  12'h048, 32'h0000_0001}, // R7 acknowledge
      {4'd7,  OP_IRQ, 12'h000, 32'h0000_0000}, // R7 gap cycle
      {4'd7,  OP_RD,  12'h040, 32'h0000_0005}, // R7 re-evaluated to 5
      {4'd5,  OP_IRQ, 12'h000, 32'h0000_0001}, // R5
      {4'd4,  OP_RD,  12'h098, 32'h0000_0020}, // R4 bank 0 pending
      {4'd5,  OP_RAW, 12'h003, 32'h8000_0000}, // R5 source 127
      {4'd5,  OP_RAW, 12'h002, 32'h0000_0002}, // R5 source 65
      {4'd2,  OP_WR,  12'h0E8, 32'h8000_0000}, // R2 unmask 127
      {4'd2,  OP_WR,  12'h0C8, 32'h0000_0002}, // R2 unmask 65
      {4'd3,  OP_WR,  12'h08C, 32'h0000_0020}, // R3 mask 5
      {4'd7,  OP_WR,  12'h048, 32'h0000_0001}, // R7
      {4'd7,  OP_RD,  12'h040, 32'h0000_0000}, // R7 reads 0 during gap
      {4'd5,  OP_RD,  12'h040, 32'h0000_0041}, // R5 lowest of 65,127
      {4'd3,  OP_WR,  12'h0CC, 32'h0000_0002}, // R3 mask 65
      {4'd7,  OP_WR,  12'h048, 32'h0000_0001}, // R7
      {4'd7,  OP_IRQ, 12'h000, 32'h0000_0000}, // R7
      {4'd5,  OP_RD,  12'h040, 32'h0000_007F}, // R5 bit 6 of number
      {4'd2,  OP_WR,  12'h0E4, 32'h0000_0000}, // R2 direct mask write
      {4'd2,  OP_RD,  12'h0E4, 32'h7FFF_FFFF}, // R2 ignored
      {4'd2,  OP_WR,  12'h0E8, 32'h0000_0000}, // R2 zero bits
      {4'd2,  OP_RD,  12'h0E4, 32'h7FFF_FFFF}, // R2
      {4'd4,  OP_RD,  12'h0F8, 32'h8000_0000}, // R4 bank 3 pending
      {4'd6,  OP_RAW, 12'h003, 32'h0000_0000}, // R6 deassert 127
      {4'd6,  OP_RD,  12'h040, 32'h0000_007F}, // R6 still latched
      {4'd6,  OP_IRQ, 12'h000, 32'h0000_0001}, // R6
      {4'd7,  OP_WR,  12'h048, 32'h0000_0001}, // R7
      {4'd7,  OP_IRQ, 12'h000, 32'h0000_0000}, // R7
      {4'd7,  OP_IRQ, 12'h000, 32'h0000_0000}, // R7 nothing pending
      {4'd10, OP_WR,  12'h068, 32'h0000_00A5}, // R10 threshold
      {4'd10, OP_RD,  12'h068, 32'h0000_00A5}, // R10
      {4'd10, OP_WR,  12'h2FC, 32'h0000_003C}, // R10 level of 127
      {4'd10, OP_RD,  12'h2FC, 32'h0000_003C}, // R10
      {4'd10, OP_WR,  12'h100, 32'h0000_0011}, // R10 level of 0
      {4'd10, OP_RD,  12'h104, 32'h0000_0000}, // R10 neighbour untouched
      {4'd10, OP_WR,  12'h04C, 32'h0000_0001}, // R10 protection
      {4'd10, OP_RD,  12'h04C, 32'h0000_0001}, // R10
      {4'd10, OP_WR,  12'h050, 32'h0000_0003}, // R10 idle
      {4'd10, OP_RD,  12'h050, 32'h0000_0003}, // R10
      {4'd10, OP_WR,  12'h010, 32'h0000_0001}, // R10 config bit 0
      {4'd10, OP_RD,  12'h300, 32'h0000_0000}  // R10 unmapped
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NS-1:0] src_irq = '0;
   logic          bus_sel = 1'b0;
   logic          bus_we = 1'b0;
   logic [11:0]   bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic          irq_out;

   int n_chk = 0;
   int n_bad = 0;

   banked_irq_ctrl #(.NUM_BANKS(NB)) dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .src_irq   (src_irq),
      .bus_sel   (bus_sel),
      .bus_we    (bus_we),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .irq_out   (irq_out)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL R%0d act=%h exp=%h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_we = 1'b0;
   endtask

   task automatic rd(input int req, input logic [11:0] a, input logic [31:0] exp);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
      #1 check(req, bus_rdata, exp);
      bus_sel = 1'b0;
   endtask

   task automatic chk_irq(input int req, input logic exp);
      @(negedge clk);
      #1 check(req, 32'(irq_out), 32'(exp));
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      n_bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      int cyc;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // table walk
      for (int i = 0; i < NV; i++) begin
         logic [49:0] v;
         v = VEC[i];
         case (v[45:44])
            OP_WR:  wr(v[43:32], v[31:0]);
            OP_RD:  rd(int'(v[49:46]), v[43:32], v[31:0]);
            OP_RAW: begin
               @(negedge clk);
               src_irq[int'(v[33:32])*32 +: 32] = v[31:0];
            end
            default: chk_irq(int'(v[49:46]), v[0]);
         endcase
      end

      // R8 soft reset while source 127 is latched
      @(negedge clk);
      src_irq[127] = 1'b1;
      chk_irq(5, 1'b1);
      wr(12'h010, 32'h0000_0003);
      bus_sel = 1'b1; bus_we = 1'b0; bus_addr = 12'h014;
      cyc = 0;
      #1;
      while (bus_rdata[0] == 1'b0 && cyc < 20) begin
         cyc++;
         @(negedge clk);
         #1;
      end
      bus_sel = 1'b0;
      check(8, 32'(cyc), 32'd4);                 // R8 four busy cycles
      // R1 state after soft reset
      rd(1, 12'h084, 32'hFFFF_FFFF);
      rd(1, 12'h0E4, 32'hFFFF_FFFF);
      rd(1, 12'h0F8, 32'h0000_0000);
      rd(1, 12'h040, 32'h0000_0000);
      chk_irq(1, 1'b0);
      rd(1, 12'h068, 32'h0000_0000);
      rd(1, 12'h2FC, 32'h0000_0000);
      rd(1, 12'h010, 32'h0000_0000);

      // R8 writes during a running soft reset are dropped
      wr(12'h010, 32'h0000_0002);
      wr(12'h068, 32'h0000_0077);
      wr(12'h0E8, 32'hFFFF_FFFF);
      repeat (6) @(negedge clk);
      rd(8, 12'h068, 32'h0000_0000);
      rd(8, 12'h0E4, 32'hFFFF_FFFF);
      chk_irq(8, 1'b0);

      // R1 hardware reset mid-operation
      wr(12'h0E8, 32'h8000_0000);
      chk_irq(1, 1'b1);
      @(negedge clk);
      rst_n = 1'b0;
      #1 check(1, 32'(irq_out), 32'd0);
      @(negedge clk);
      rst_n = 1'b1;
      rd(1, 12'h0E4, 32'hFFFF_FFFF);
      rd(9, 12'h000, 32'h0000_0041);

      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule